// File: doc/BRIEF.md
# Frame-Sync Ratio Integrity Monitor

The block watches a frame-pulse sync input that travels with a reference clock. It times the interval between sync rising edges in master-clock cycles and classifies the sync rate as 8 kHz or 2 kHz. It counts reference-clock rising edges inside each sync period. It then compares that count with the whole number that a configured reference frequency and the detected rate call for.

A digital loop uses the three outputs. `rate_o` reports the detected sync rate. `valid_o` shows that alignment to the sync pulse can be trusted. `fail_o` shows that the sync has broken its ratio with the reference. In that case the loop stops aligning its output frame pulse to the sync and tracks the reference clock alone.

Both inputs may be asynchronous. They pass through two-flop synchronizers into the master domain, and rising edges are found there. The reference frequency must stay below half the master clock.

Top module: `fsr_ratio_mon`

## Requirements
- R1: After reset, `rate_o` is 0 (none), `valid_o` is 0 and `fail_o` is 0.
- R2: If the interval between two sync rising edges is between 2375 and 2625 master clocks, the rate is classified as 8 kHz, reported on `rate_o` as 2'b01.
- R3: If the interval is between 9500 and 10500 master clocks, the rate is classified as 2 kHz, reported on `rate_o` as 2'b10.
- R4: If an interval falls outside both bands, `rate_o` becomes 0 and `valid_o` is cleared.
- R5: If no sync edge arrives within 12000 master clocks of the last one, `rate_o` becomes 0 and `valid_o` is cleared. The first sync edge after that starts a new interval and is not judged.
- R6: The expected reference count per 8 kHz period depends on `ref_sel`: 0 gives 256, 1 gives 193, 2 gives 8 and 3 gives 1024. At 2 kHz the expected count is four times that value. A count is judged against the `ref_sel` value that is present when the period ends.
- R7: A judged period whose count differs from the expected count sets `fail_o` and clears `valid_o`. The difference may be as small as one cycle in either direction.
- R8: Once set, `fail_o` stays set until two consecutive good periods have been judged. At that point it clears and `valid_o` sets. `valid_o` and `fail_o` are never both 1.
- R9: After reset, after a timeout, or when an interval classifies as a rate different from the current one, that interval's count is discarded. `valid_o` rises only after two consecutive good periods at the established rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock that times all intervals |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous |
| sync_in | input | 1 | Frame-pulse sync, asynchronous, active high |
| ref_sel | input | 2 | Reference frequency select (see R6) |
| rate_o | output | 2 | Detected rate: 00 none, 01 8 kHz, 10 2 kHz |
| valid_o | output | 1 | Sync ratio verified |
| fail_o | output | 1 | Sync ratio failure: track the reference only |

## Verification
Trains of exact-ratio periods at 8 kHz and 2 kHz show how many periods are needed before `valid_o` rises, and that a change of rate discards a period. Counts that are one too low or one too high, and counts that are correct for a different `ref_sel`, show that the comparison is exact and that the table entry is chosen correctly. The bench also checks that the failure is held through one good period. An over-long interval and a pause with no sync pulse separate an out-of-band classification from a timeout, and show that the edge after a timeout is not judged.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    RATE_NONE = 2'b00,
    RATE_8K   = 2'b01,
    RATE_2K   = 2'b10
  } rate_e;

  // Window test: ivl within nom +/- tol percent
  function automatic logic in_band(input int unsigned ivl, input int unsigned nom,
                                   input int unsigned tol);
    return (ivl * 100 >= nom * (100 - tol)) && (ivl * 100 <= nom * (100 + tol));
  endfunction

  function automatic rate_e classify(input int unsigned ivl, input int unsigned nom8,
                                     input int unsigned nom2, input int unsigned tol);
    if (in_band(ivl, nom8, tol)) return RATE_8K;
    if (in_band(ivl, nom2, tol)) return RATE_2K;
    return RATE_NONE;
  endfunction

  // Reference edges per sync period
  function automatic int unsigned expected_count(input logic [1:0] sel, input rate_e r);
    int unsigned base;
    case (sel)
      2'd0:    base = 256;
      2'd1:    base = 193;
      2'd2:    base = 8;
      default: base = 1024;
    endcase
    return (r == RATE_2K) ? base * 4 : base;
  endfunction

endpackage

// File: rtl/fsr_edge_sync.sv
module fsr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], d};
  end

  assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/fsr_rate_meter.sv
module fsr_rate_meter
  import fsr_pkg::*;
#(
  parameter int unsigned NOM8    = 2500,
  parameter int unsigned NOM2    = 10000,
  parameter int unsigned TOL_PCT = 5,
  parameter int unsigned TIMEOUT = 12000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_rise,
  output logic  period_done,
  output rate_e period_cls,
  output logic  absent_evt
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] ivl_q;
  logic          armed_q;

  assign absent_evt  = armed_q && !sync_rise && (ivl_q == CW'(TIMEOUT - 1));
  assign period_done = sync_rise && armed_q;
  assign period_cls  = classify(32'(ivl_q) + 32'd1, NOM8, NOM2, TOL_PCT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q   <= '0;
      armed_q <= 1'b0;
    end else if (sync_rise) begin
      ivl_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (ivl_q != CW'(TIMEOUT)) ivl_q <= ivl_q + 1'b1;
      if (absent_evt) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fsr_ratio_judge.sv
module fsr_ratio_judge
  import fsr_pkg::*;
#(
  parameter int unsigned REF_W     = 13,
  parameter int unsigned GOOD_NEED = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_rise,
  input  logic       sync_rise,
  input  logic       period_done,
  input  rate_e      period_cls,
  input  logic       absent_evt,
  input  logic [1:0] ref_sel,
  output rate_e      rate,
  output logic       valid,
  output logic       fail,
  output logic       good_evt,
  output logic       bad_evt
);
  localparam int unsigned GW = $clog2(GOOD_NEED + 1);

  logic [REF_W-1:0] cnt_q;
  logic [GW-1:0]    good_q;
  logic             judged;
  logic [REF_W-1:0] exp_cnt;

  assign exp_cnt  = REF_W'(expected_count(ref_sel, period_cls));
  assign judged   = period_done && (period_cls != RATE_NONE) && (period_cls == rate);
  assign good_evt = judged && (cnt_q == exp_cnt);
  assign bad_evt  = judged && (cnt_q != exp_cnt);

  // Reference edge counter; an edge on the sync cycle opens the new period
  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (sync_rise)            cnt_q <= REF_W'(ref_rise);
    else if (ref_rise && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate   <= RATE_NONE;
      valid  <= 1'b0;
      fail   <= 1'b0;
      good_q <= '0;
    end else if (absent_evt) begin
      rate   <= RATE_NONE;
      valid  <= 1'b0;
      good_q <= '0;
    end else if (period_done) begin
      if (period_cls != rate) begin
        rate   <= period_cls;
        valid  <= 1'b0;
        good_q <= '0;
      end else if (good_evt) begin
        if (good_q != GW'(GOOD_NEED)) good_q <= good_q + 1'b1;
        if (32'(good_q) + 1 >= GOOD_NEED) begin
          valid <= 1'b1;
          fail  <= 1'b0;
        end
      end else if (bad_evt) begin
        fail   <= 1'b1;
        valid  <= 1'b0;
        good_q <= '0;
      end
    end
  end
endmodule

// File: rtl/fsr_ratio_mon.sv
module fsr_ratio_mon
  import fsr_pkg::*;
#(
  parameter int unsigned NOM8      = 2500,
  parameter int unsigned NOM2      = 10000,
  parameter int unsigned TOL_PCT   = 5,
  parameter int unsigned TIMEOUT   = 12000,
  parameter int unsigned REF_W     = 13,
  parameter int unsigned GOOD_NEED = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk_in,
  input  logic       sync_in,
  input  logic [1:0] ref_sel,
  output logic [1:0] rate_o,
  output logic       valid_o,
  output logic       fail_o
);
  logic  ref_rise, sync_rise;
  logic  period_done, absent_evt, good_evt, bad_evt;
  rate_e period_cls, rate;

  fsr_edge_sync u_ref_sync  (.clk(clk), .rst_n(rst_n), .d(ref_clk_in), .rise(ref_rise));
  fsr_edge_sync u_sync_sync (.clk(clk), .rst_n(rst_n), .d(sync_in),    .rise(sync_rise));

  fsr_rate_meter #(
    .NOM8(NOM8), .NOM2(NOM2), .TOL_PCT(TOL_PCT), .TIMEOUT(TIMEOUT)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise),
    .period_done(period_done), .period_cls(period_cls), .absent_evt(absent_evt)
  );

  fsr_ratio_judge #(.REF_W(REF_W), .GOOD_NEED(GOOD_NEED)) u_judge (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .sync_rise(sync_rise),
    .period_done(period_done), .period_cls(period_cls), .absent_evt(absent_evt),
    .ref_sel(ref_sel), .rate(rate), .valid(valid_o), .fail(fail_o),
    .good_evt(good_evt), .bad_evt(bad_evt)
  );

  assign rate_o = rate;
endmodule

// File: rtl/fsr_ratio_mon_chk.sv
module fsr_ratio_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rate,
  input logic       valid,
  input logic       fail,
  input logic       period_done,
  input logic       absent_evt,
  input logic       good_evt,
  input logic       bad_evt
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rate == 2'b00 && !valid && !fail));

  a_r2_rate_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate) |-> $past(period_done || absent_evt));

  a_r4_valid_has_rate: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> rate != 2'b00);

  a_r5_absent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    absent_evt |=> (rate == 2'b00 && !valid));

  a_r7_bad_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (fail && !valid));

  a_r8_fail_clears_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail) |-> $past(good_evt));

  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && fail));

  a_r9_valid_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(good_evt));
endmodule

bind fsr_ratio_mon fsr_ratio_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rate(rate_o), .valid(valid_o), .fail(fail_o),
  .period_done(period_done), .absent_evt(absent_evt),
  .good_evt(good_evt), .bad_evt(bad_evt)
);

// File: tb/sim_fsr_ratio_mon.sv
module sim_fsr_ratio_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk_in = 1'b0;
  logic       sync_in = 1'b0;
  logic [1:0] ref_sel = 2'd0;
  logic [1:0] rate_o;
  logic       valid_o, fail_o;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fsr_ratio_mon u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .sync_in(sync_in),
    .ref_sel(ref_sel), .rate_o(rate_o), .valid_o(valid_o), .fail_o(fail_o)
  );

  task automatic expect_st(input string tag, input int rate_x, input int valid_x,
                           input int fail_x);
    n_chk++;
    if (int'(rate_o) != rate_x || int'(valid_o) != valid_x || int'(fail_o) != fail_x) begin
      n_bad++;
      $display("FAIL %s: rate/valid/fail act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               tag, rate_o, valid_o, fail_o, rate_x, valid_x, fail_x);
    end
  endtask

  // One sync period of p master clocks carrying nref reference cycles
  task automatic run_period(input int p, input int nref, input logic [1:0] sel);
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      sync_in = (c < 2);
      if (c == 8) ref_sel = sel;
      if (c >= 10 && c < 10 + 8 * nref) ref_clk_in = ((c - 10) % 8) < 4;
      else ref_clk_in = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      sync_in = 1'b0;
      ref_clk_in = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    expect_st("R1 reset", 0, 0, 0);
  endtask

  task automatic t_8k_lock;
    run_period(2500, 256, 0);
    expect_st("R9 first edge unjudged", 0, 0, 0);
    run_period(2500, 256, 0);
    expect_st("R2 R9 rate set, period discarded", 1, 0, 0);
    run_period(2500, 256, 0);
    expect_st("R9 one good period", 1, 0, 0);
    run_period(2500, 256, 0);
    expect_st("R2 valid after two good", 1, 1, 0);
  endtask

  task automatic t_off_by_one;
    run_period(2500, 255, 0);
    expect_st("R7 before short period", 1, 1, 0);
    run_period(2500, 256, 0);
    expect_st("R7 count 255 fails", 1, 0, 1);
    run_period(2500, 256, 0);
    expect_st("R8 fail held after one good", 1, 0, 1);
    run_period(2500, 257, 0);
    expect_st("R8 fail cleared after two good", 1, 1, 0);
    run_period(2500, 256, 0);
    expect_st("R7 count 257 fails", 1, 0, 1);
    run_period(2500, 256, 0);
    run_period(2500, 256, 0);
    expect_st("R8 recovered", 1, 1, 0);
  endtask

  task automatic t_ref_select;
    run_period(2500, 193, 1);
    run_period(2500, 193, 1);
    expect_st("R6 sel1 193 good", 1, 1, 0);
    run_period(2500, 8, 2);
    run_period(2500, 256, 2);
    expect_st("R6 sel2 8 good", 1, 1, 0);
    run_period(2500, 256, 0);
    expect_st("R6 256 under sel2 fails", 1, 0, 1);
    run_period(2500, 256, 0);
    run_period(2500, 256, 0);
    expect_st("R6 back to sel0", 1, 1, 0);
  endtask

  task automatic t_2k;
    run_period(10000, 1024, 0);
    run_period(10000, 1024, 0);
    expect_st("R3 R9 rate change discards", 2, 0, 0);
    run_period(10000, 1024, 0);
    expect_st("R9 2k one good", 2, 0, 0);
    run_period(10000, 256, 0);
    expect_st("R3 2k valid", 2, 1, 0);
    run_period(10000, 1024, 0);
    expect_st("R6 2k needs x4 count", 2, 0, 1);
  endtask

  task automatic t_out_of_band_and_gap;
    run_period(3000, 256, 0);
    run_period(2500, 256, 0);
    expect_st("R4 3000 clocks out of band", 0, 0, 1);
    run_period(2500, 256, 0);
    expect_st("R2 rate re-established", 1, 0, 1);
    idle(13000);
    expect_st("R5 timeout clears rate", 0, 0, 1);
    run_period(2500, 256, 0);
    expect_st("R5 first edge after timeout unjudged", 0, 0, 1);
    run_period(2500, 256, 0);
    expect_st("R5 R9 rate set again, discarded", 1, 0, 1);
    run_period(2500, 256, 0);
    run_period(2500, 256, 0);
    expect_st("R8 fail cleared after restart", 1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_8k_lock();
    t_off_by_one();
    t_ref_select();
    t_2k();
    t_out_of_band_and_gap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule